// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This block sits between a processor core and a data memory that is one 32-bit word wide. For every memory operation it forms the effective address, which is a base register value plus a sign-extended 16-bit displacement. It then works out which byte lanes of the word the operation touches. The memory is byte-addressed and big-endian: the byte at the lowest address of a word occupies the most significant lane.

For a store, the unit turns the access width and the low address bits into per-lane write enables. It also places the register value on the lanes where the memory will take it, so a byte or halfword store leaves the rest of the word untouched. For a load, it picks the addressed byte or halfword out of the word the memory returns. It then sign- or zero-extends that value to a full register value. An access whose address does not suit its width raises a flag and causes no memory activity.

The request side is one cycle: valid, direction, width, signedness, base, displacement and store value. The memory sees a registered word address, write enables, write data and a read strobe one cycle after the request. A synchronous-read memory returns the word one cycle later, and the extended load result is valid in that same cycle.

Top module: `beLaneUnit`

## Requirements
- R1: One cycle after a request, memAddr equals reqBase plus reqOffset sign-extended to 32 bits, with bits [1:0] forced to zero; memAddr follows the inputs every cycle.
- R2: Lane mapping is big-endian: memWe bit 3 enables bits [31:24] and bit 0 enables bits [7:0]. An aligned store of a byte at offset k (the two low address bits) sets only memWe bit 3-k. A halfword at offset 0 gives 4'b1100 and at offset 2 gives 4'b0011. A word gives 4'b1111. All of these appear one cycle after the request.
- R3: memWdata is the low byte of reqStoreData copied into all four lanes for a byte, the low halfword copied into both halves for a halfword, and reqStoreData unchanged for a word or reserved width. Bytes whose enable is low keep their old memory contents.
- R4: reqSize encodes width as 2'b00 byte, 2'b01 halfword and 2'b10 word. 2'b11 is reserved, and a valid request with it is always treated as misaligned.
- R5: A valid request is misaligned when it is a halfword at an odd address or a word whose address bits [1:0] are not zero. One cycle later misalign is 1, memWe is 4'b0000 and memRe is 0.
- R6: memRe is 1 exactly one cycle after a valid, aligned load (reqStore=0), and 0 otherwise.
- R7: For a byte load at offset k, the result is the byte in bits [31-8k:24-8k] of memRdata. It is sign-extended when reqUnsigned=0 and zero-extended when reqUnsigned=1. The result appears on loadData with loadValid=1 two cycles after the request.
- R8: For a halfword load, offset 0 takes memRdata[31:16] and offset 2 takes memRdata[15:0]. The halfword is sign-extended when reqUnsigned=0 and zero-extended when reqUnsigned=1. It is delivered like R7.
- R9: A word load returns memRdata unchanged, whatever reqUnsigned is. It is delivered like R7.
- R10: During and right after reset, all outputs are zero, and loadData is zero in every cycle in which loadValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqStore | input | 1 | 1 store, 0 load |
| reqSize | input | 2 | Access width code (R4) |
| reqUnsigned | input | 1 | Zero-extend a load when 1 |
| reqBase | input | 32 | Base register value |
| reqOffset | input | 16 | Signed displacement |
| reqStoreData | input | 32 | Register value to store |
| memRdata | input | 32 | Word returned by memory, one cycle after memRe |
| memAddr | output | 32 | Word-aligned memory address |
| memWe | output | 4 | Per-lane write enables, bit 3 = bits [31:24] |
| memWdata | output | 32 | Lane-placed store data |
| memRe | output | 1 | Read strobe for an aligned load |
| misalign | output | 1 | The previous request was misaligned |
| loadValid | output | 1 | loadData holds a load result |
| loadData | output | 32 | Extended load result |

## Verification
The memory-side outputs (memAddr, memWe, memWdata, memRe, misalign) are due one cycle after the request that causes them. The load result is due two cycles after the request, because the bench memory returns the word on the clock edge that follows memRe. The reference model in the bench follows the same two stages with its own shadow memory and is updated on each rising edge. All outputs are compared with it on each falling edge, so every comparison meets the value in the cycle it is due and never the value in a cycle of change. Each load-result comparison is tagged with the requirement that the delayed access width selects. Directed cases cover every lane offset, both kinds of extension, each misalignment and the reserved width, before a long pseudo-random run.

// File: rtl/lsuPkg.sv
package lsuPkg;
  localparam int LANE_W = 8;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int LOW_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  typedef struct packed {
    logic [LANES-1:0] byteEn;
    logic             readEn;
    logic             misalign;
  } laneStrobe_t;
endpackage

// File: rtl/lsuCtrl.sv
module lsuCtrl
  import lsuPkg::*;
(
  input  logic             reqValid,
  input  logic             reqStore,
  input  accSize_e         reqSize,
  input  logic [LOW_W-1:0] lowAddr,
  output laneStrobe_t      strb
);
  logic             alignOk;
  logic [LANES-1:0] laneMask;

  always_comb begin
    alignOk  = 1'b0;
    laneMask = '0;
    unique case (reqSize)
      SZ_BYTE: begin
        alignOk  = 1'b1;
        laneMask = {1'b1, {(LANES-1){1'b0}}} >> lowAddr;
      end
      SZ_HALF: begin
        alignOk  = ~lowAddr[0];
        laneMask = lowAddr[1] ? {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}}
                              : {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}};
      end
      SZ_WORD: begin
        alignOk  = (lowAddr == '0);
        laneMask = '1;
      end
      default: begin
        alignOk  = 1'b0;
        laneMask = '0;
      end
    endcase
  end

  always_comb begin
    strb.misalign = reqValid & ~alignOk;
    strb.readEn   = reqValid & ~reqStore & alignOk;
    strb.byteEn   = (reqValid & reqStore & alignOk) ? laneMask : '0;
  end
endmodule

// File: rtl/lsuDatapath.sv
module lsuDatapath
  import lsuPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  accSize_e          reqSize,
  input  logic              reqUnsigned,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [WORD_W-1:0] reqStoreData,
  input  logic [WORD_W-1:0] memRdata,
  input  laneStrobe_t       strb,
  output logic [LOW_W-1:0]  lowAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memWe,
  output logic [WORD_W-1:0] memWdata,
  output logic              memRe,
  output logic              misalign,
  output logic              loadValid,
  output logic [WORD_W-1:0] loadData
);
  localparam int HALF_W = WORD_W / 2;

  logic [ADDR_W-1:0] effAddr;
  logic [WORD_W-1:0] placedData;
  logic [LOW_W-1:0]  s1Low,  s2Low;
  accSize_e          s1Size, s2Size;
  logic              s1Uns,  s2Uns;
  logic [LANE_W-1:0] rdLane [LANES];
  logic [LANE_W-1:0] pickByte;
  logic [HALF_W-1:0] pickHalf;
  logic [WORD_W-1:0] extData;

  assign effAddr = reqBase + {{(ADDR_W-OFF_W){reqOffset[OFF_W-1]}}, reqOffset};
  assign lowAddr = effAddr[LOW_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    // lane g holds the byte at offset g (most significant first)
    localparam int HI = WORD_W - 1 - g * LANE_W;
    assign rdLane[g] = memRdata[HI -: LANE_W];
    always_comb begin
      unique case (reqSize)
        SZ_BYTE: placedData[HI -: LANE_W] = reqStoreData[LANE_W-1:0];
        SZ_HALF: placedData[HI -: LANE_W] = (g % 2 == 0) ? reqStoreData[HALF_W-1 -: LANE_W]
                                                          : reqStoreData[LANE_W-1:0];
        default: placedData[HI -: LANE_W] = reqStoreData[HI -: LANE_W];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr   <= '0;
      memWe     <= '0;
      memWdata  <= '0;
      memRe     <= 1'b0;
      misalign  <= 1'b0;
      s1Low     <= '0;
      s1Size    <= SZ_BYTE;
      s1Uns     <= 1'b0;
      loadValid <= 1'b0;
      s2Low     <= '0;
      s2Size    <= SZ_BYTE;
      s2Uns     <= 1'b0;
    end else begin
      memAddr   <= {effAddr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
      memWe     <= strb.byteEn;
      memWdata  <= placedData;
      memRe     <= strb.readEn;
      misalign  <= strb.misalign;
      s1Low     <= lowAddr;
      s1Size    <= reqSize;
      s1Uns     <= reqUnsigned;
      loadValid <= memRe;
      s2Low     <= s1Low;
      s2Size    <= s1Size;
      s2Uns     <= s1Uns;
    end
  end

  always_comb begin
    pickByte = rdLane[s2Low];
    pickHalf = s2Low[1] ? memRdata[HALF_W-1:0] : memRdata[WORD_W-1:HALF_W];
    unique case (s2Size)
      SZ_BYTE: extData = {{(WORD_W-LANE_W){~s2Uns & pickByte[LANE_W-1]}}, pickByte};
      SZ_HALF: extData = {{(WORD_W-HALF_W){~s2Uns & pickHalf[HALF_W-1]}}, pickHalf};
      default: extData = memRdata;
    endcase
  end

  assign loadData = loadValid ? extData : '0;

  // R5: a flagged access never reaches memory
  a_r5_misalign_quiet: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (memWe == '0) && !memRe);

  // R6: a read strobe is answered by a result exactly one cycle later
  a_r6_read_to_result: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> loadValid);

  a_r6_no_spurious_result: assert property (@(posedge clk) disable iff (!rstN)
    !memRe |=> !loadValid);

  // R10: the result bus is idle-zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> (loadData == '0));
endmodule

// File: rtl/beLaneUnit.sv
module beLaneUnit
  import lsuPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqSize,
  input  logic              reqUnsigned,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [WORD_W-1:0] reqStoreData,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memWe,
  output logic [WORD_W-1:0] memWdata,
  output logic              memRe,
  output logic              misalign,
  output logic              loadValid,
  output logic [WORD_W-1:0] loadData
);
  laneStrobe_t      strb;
  logic [LOW_W-1:0] lowAddr;
  accSize_e         sizeCode;

  assign sizeCode = accSize_e'(reqSize);

  lsuCtrl ctrl_i (
    .reqValid (reqValid),
    .reqStore (reqStore),
    .reqSize  (sizeCode),
    .lowAddr  (lowAddr),
    .strb     (strb)
  );

  lsuDatapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqSize      (sizeCode),
    .reqUnsigned  (reqUnsigned),
    .reqBase      (reqBase),
    .reqOffset    (reqOffset),
    .reqStoreData (reqStoreData),
    .memRdata     (memRdata),
    .strb         (strb),
    .lowAddr      (lowAddr),
    .memAddr      (memAddr),
    .memWe        (memWe),
    .memWdata     (memWdata),
    .memRe        (memRe),
    .misalign     (misalign),
    .loadValid    (loadValid),
    .loadData     (loadData)
  );

  // R2: enables form one byte, one aligned half or the full word
  a_r2_lane_shape: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(memWe) == 0) || ($countones(memWe) == 1) ||
    ($countones(memWe) == 2) || ($countones(memWe) == 4));

  a_r6_read_write_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && (memWe != '0)));
endmodule

// File: tb/beLaneUnit_tb_top.sv
module beLaneUnit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqStore = 1'b0, reqUnsigned = 1'b0;
  logic [1:0]  reqSize = 2'b00;
  logic [31:0] reqBase = '0, reqStoreData = '0;
  logic [15:0] reqOffset = '0;
  logic [31:0] memRdata, memAddr, memWdata, loadData;
  logic [3:0]  memWe;
  logic        memRe, misalign, loadValid;

  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  beLaneUnit dut_i (.*);

  // bench memory driven by the DUT (16 words, synchronous read)
  logic [31:0] realMem [16];
  logic [31:0] shadow  [16];
  always @(posedge clk) begin
    memRdata <= realMem[memAddr[5:2]];
    for (int k = 0; k < 4; k++)
      if (memWe[k]) realMem[memAddr[5:2]][8*k +: 8] <= memWdata[8*k +: 8];
  end

  // reference model
  logic [31:0] e1Addr, e1Wd; logic [3:0] e1We; logic e1Re, e1Mis; logic [1:0] e1Lo, e1Sz; logic e1Uns;
  logic [31:0] e2Data; logic e2Lv; logic [1:0] e2Sz, e1SzRaw;

  function automatic logic [31:0] extend(input logic [31:0] w, input logic [1:0] lo,
                                         input logic [1:0] sz, input logic uns);
    logic [31:0] v;
    if (sz == 2'b00) begin
      v = (w >> (8 * (3 - lo))) & 32'hFF;
      if (!uns && v[7]) v = v | 32'hFFFF_FF00;
    end else if (sz == 2'b01) begin
      v = lo[1] ? (w & 32'hFFFF) : (w >> 16);
      if (!uns && v[15]) v = v | 32'hFFFF_0000;
    end else v = w;
    return v;
  endfunction

  always @(posedge clk) begin
    logic [31:0] ea; logic bad; logic [3:0] en; logic [31:0] wd;
    if (!rstN) begin
      e1Addr <= 0; e1Wd <= 0; e1We <= 0; e1Re <= 0; e1Mis <= 0; e1Lo <= 0; e1Sz <= 0; e1Uns <= 0;
      e2Data <= 0; e2Lv <= 0; e2Sz <= 0; e1SzRaw <= 0;
    end else begin
      e2Lv   <= e1Re;
      e2Sz   <= e1Sz;
      e2Data <= e1Re ? extend(shadow[e1Addr[5:2]], e1Lo, e1Sz, e1Uns) : 32'h0;
      for (int k = 0; k < 4; k++)
        if (e1We[k]) shadow[e1Addr[5:2]][8*k +: 8] <= e1Wd[8*k +: 8];
      ea  = reqBase + 32'(signed'(reqOffset));
      bad = (reqSize == 2'b11) || (reqSize == 2'b01 && ea[0]) || (reqSize == 2'b10 && ea[1:0] != 0);
      if (reqSize == 2'b00)      begin en = 4'(8 >> ea[1:0]); wd = {4{reqStoreData[7:0]}}; end
      else if (reqSize == 2'b01) begin en = ea[1] ? 4'b0011 : 4'b1100; wd = {2{reqStoreData[15:0]}}; end
      else                       begin en = 4'b1111; wd = reqStoreData; end
      e1Addr  <= ea & 32'hFFFF_FFFC;
      e1Wd    <= wd;
      e1We    <= (reqValid && reqStore && !bad) ? en : 4'b0000;
      e1Re    <= reqValid && !reqStore && !bad;
      e1Mis   <= reqValid && bad;
      e1Lo    <= ea[1:0];
      e1Sz    <= reqSize;
      e1SzRaw <= reqSize;
      e1Uns   <= reqUnsigned;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  bit compareOn = 1'b0;
  always @(negedge clk) begin
    cycles++;
    if (compareOn) begin
      check("R1 memAddr", memAddr, e1Addr);
      check("R2 memWe", {28'h0, memWe}, {28'h0, e1We});
      check("R3 memWdata", memWdata, e1Wd);
      check(e1SzRaw == 2'b11 ? "R4 reserved width" : "R5 misalign", {31'h0, misalign}, {31'h0, e1Mis});
      check("R6 memRe", {31'h0, memRe}, {31'h0, e1Re});
      check("R10 loadValid", {31'h0, loadValid}, {31'h0, e2Lv});
      if (!e2Lv)              check("R10 loadData idle", loadData, e2Data);
      else if (e2Sz == 2'b00) check("R7 byte load", loadData, e2Data);
      else if (e2Sz == 2'b01) check("R8 half load", loadData, e2Data);
      else                    check("R9 word load", loadData, e2Data);
    end
  end

  task automatic issue(input logic st, input logic [1:0] sz, input logic uns,
                       input logic [31:0] base, input logic [15:0] off, input logic [31:0] sd);
    @(negedge clk);
    reqValid = 1'b1; reqStore = st; reqSize = sz; reqUnsigned = uns;
    reqBase = base; reqOffset = off; reqStoreData = sd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      realMem[i] = 32'h80F1_7E03 ^ (i * 32'h0113_0517);
      shadow[i]  = realMem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset memWe", {28'h0, memWe}, 32'h0);
    check("R10 reset memRe/misalign/loadValid", {29'h0, memRe, misalign, loadValid}, 32'h0);
    check("R10 reset loadData", loadData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 after reset memAddr", memAddr, 32'h0);
    compareOn = 1'b1;
    // R1: negative displacement
    issue(1'b0, 2'b10, 1'b0, 32'h0000_0120, 16'hFFF0, 0);
    // R2/R3: byte stores at every offset, then half and word stores
    for (int k = 0; k < 4; k++) issue(1'b1, 2'b00, 1'b0, 32'h40, 16'(k), 32'hA5A5_A580 + k);
    issue(1'b1, 2'b01, 1'b0, 32'h44, 16'h0000, 32'h1234_F00D);
    issue(1'b1, 2'b01, 1'b0, 32'h44, 16'h0002, 32'h5678_8001);
    issue(1'b1, 2'b10, 1'b0, 32'h48, 16'h0000, 32'hDEAD_BEEF);
    idle(2);
    // R7: byte loads signed and unsigned at every offset
    for (int k = 0; k < 4; k++) begin
      issue(1'b0, 2'b00, 1'b0, 32'h40, 16'(k), 0);
      issue(1'b0, 2'b00, 1'b1, 32'h40, 16'(k), 0);
    end
    // R8, R9
    issue(1'b0, 2'b01, 1'b0, 32'h44, 16'h0002, 0);
    issue(1'b0, 2'b01, 1'b1, 32'h44, 16'h0002, 0);
    issue(1'b0, 2'b01, 1'b0, 32'h44, 16'h0000, 0);
    issue(1'b0, 2'b10, 1'b1, 32'h48, 16'h0000, 0);
    // R5 misaligned, R4 reserved width
    issue(1'b1, 2'b01, 1'b0, 32'h44, 16'h0001, 32'hFFFF_FFFF);
    issue(1'b1, 2'b10, 1'b0, 32'h48, 16'h0002, 32'hFFFF_FFFF);
    issue(1'b0, 2'b10, 1'b0, 32'h48, 16'h0003, 0);
    issue(1'b1, 2'b11, 1'b0, 32'h48, 16'h0000, 32'hFFFF_FFFF);
    issue(1'b0, 2'b11, 1'b0, 32'h48, 16'h0000, 0);
    // R3: untouched lanes kept; read back the words
    issue(1'b0, 2'b10, 1'b0, 32'h44, 16'h0000, 0);
    issue(1'b0, 2'b10, 1'b0, 32'h48, 16'h0000, 0);
    idle(2);
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 5 == 0) idle(1);
      else issue(1'($urandom), 2'($urandom), 1'($urandom), $urandom, 16'($urandom), $urandom);
    end
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule